// File: doc/BRIEF.md
# Dual Four-Mode Timer/Counter

This block holds two up-counters. Each counter is split into a low byte and a high byte. Every counter advances on one of two kinds of event, chosen per timer:

- a machine-cycle strobe supplied by the surrounding logic, or
- a falling edge on its own external count pin, sampled once per strobe.

Each timer has a run bit, a gate bit and an external gate pin that together decide whether counting may proceed. When a counter wraps, its overflow flag is raised. A one-cycle acknowledge pulse clears the flag when the interrupt is taken.

Four counting arrangements are available per timer: a 13-bit counter whose low five bits act as a divide-by-32 prescaler, a full 16-bit counter, an 8-bit counter that reloads from the high byte, and a split arrangement. In the split arrangement, timer 0 becomes two independent 8-bit counters and timer 1 stops.

Software reaches the counter bytes, the two configuration bytes and the flags through a byte-wide register port. Writes take effect at the clock edge and reads are combinational.

Top module: `tcnt_unit`

## Requirements
- R1: After reset, all four counter bytes, both configuration bytes and both overflow flags read as zero.
- R2: Register addresses are 0 = timer-0 low, 1 = timer-0 high, 2 = timer-1 low, 3 = timer-1 high, 4 = timer-0 configuration, 5 = timer-1 configuration, 6 = flags (bit 0 timer 0, bit 1 timer 1), 7 reads zero. A configuration byte has mode in bits 1:0 (0 = 13-bit, 1 = 16-bit, 2 = 8-bit reload, 3 = split), external-count select in bit 2, gate in bit 3 and run in bit 4. Writes land at the clock edge and reads reflect the current state combinationally.
- R3: Counter state changes only in a cycle where the machine-cycle strobe is high, unless a register write occurs. With the internal source selected, each strobe cycle counts once. The new value is visible the cycle after.
- R4: A timer counts only when its run bit is 1 and either its gate bit is 0 or its external gate pin is high.
- R5: With external-count select set, the count pin is sampled at every strobe. One count occurs at a strobe whose sample is low when the previous sample was high, so changes between strobes are not seen. The new value is visible the cycle after that strobe.
- R6: In mode 0 the low five bits of the low byte form a divide-by-32 prescaler that carries into the high byte. The upper three bits of the low byte are left untouched. The flag is set when all 13 bits wrap to zero.
- R7: In mode 1 the two bytes form a 16-bit counter, and the flag is set when it wraps from FFFFh to 0000h.
- R8: In mode 2 the low byte counts. When it is FFh, a count reloads it from the high byte and sets the flag; the high byte does not change.
- R9: When timer 0 is in mode 3, its low byte is an 8-bit counter that uses timer 0's source, gate, run bit and flag. Its high byte counts every strobe while timer 1's run bit is 1, and sets timer 1's flag on wrap. While timer 0 is split, a timer-1 wrap does not set timer 1's flag.
- R10: When timer 1 is in mode 3, timer 1 holds both bytes.
- R11: A flag is cleared by its acknowledge pulse. An overflow in the same cycle as the acknowledge leaves the flag set.
- R12: A write to a counter byte in the same cycle as a count replaces that byte's new value. The other byte and the flag still follow the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| mcStrobe | input | 1 | One-cycle machine-cycle strobe |
| regWe | input | 1 | Register write enable |
| regAddr | input | 3 | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational) |
| extCnt | input | 2 | External count pins, bit i for timer i |
| extGate | input | 2 | External gate pins, bit i for timer i |
| ackTimer | input | 2 | Interrupt-taken pulses that clear the flags |
| ovfFlag | output | 2 | Overflow flags |

## Verification
The bench targets the exact carry points:

- the prescaler wrap at 31 with the upper low-byte bits preserved, which an off-by-one or a full-byte increment would corrupt;
- the FFFFh wrap;
- the FFh reload, which a design that also cleared the high byte would break.

In split mode it confirms two things. Timer 0's high byte must borrow timer 1's run bit and flag, which a design that kept timer 0's controls would miss. Timer 1 must freeze and must not raise its flag while timer 0 is split.

For the count pin it applies single-strobe pulses that must count, and glitches between strobes that must not. It also drives a strobe, a write and an acknowledge in the same cycle, where a design with the wrong precedence would lose the write or drop a fresh overflow.

// File: rtl/tcnt_pkg.sv
`timescale 1ns/100ps
package tcnt_pkg;
  localparam int NUM_TMR = 2;

  typedef enum logic [1:0] {
    MODE_PRE13   = 2'd0,
    MODE_FULL16  = 2'd1,
    MODE_RELOAD8 = 2'd2,
    MODE_SPLIT   = 2'd3
  } tmrMode_e;

  // Configuration byte layout: run[4] gate[3] extSrc[2] mode[1:0]
  typedef struct packed {
    logic     run;
    logic     gate;
    logic     extSrc;
    tmrMode_e mode;
  } tmrCfg_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic [NUM_TMR-1:0] tick;
    logic               splitTick;
    logic [NUM_TMR-1:0] wrLo;
    logic [NUM_TMR-1:0] wrHi;
  } tmrStrobe_t;

  localparam int ADDR_LO0  = 0;
  localparam int ADDR_HI0  = 1;
  localparam int ADDR_LO1  = 2;
  localparam int ADDR_HI1  = 3;
  localparam int ADDR_CFG0 = 4;
  localparam int ADDR_CFG1 = 5;
  localparam int ADDR_FLAG = 6;
endpackage

// File: rtl/tcnt_ctrl.sv
`timescale 1ns/100ps
module tcnt_ctrl
  import tcnt_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     mcStrobe,
  input  logic                     regWe,
  input  logic [ADDR_W-1:0]        regAddr,
  input  logic [BYTE_W-1:0]        regWdata,
  input  logic [NUM_TMR-1:0]       extCnt,
  input  logic [NUM_TMR-1:0]       extGate,
  output tmrCfg_t [NUM_TMR-1:0]    cfg,
  output tmrStrobe_t               strb
);
  localparam int CFG_W = $bits(tmrCfg_t);

  logic [NUM_TMR-1:0] sampQ;
  logic [NUM_TMR-1:0] tickV;
  logic [NUM_TMR-1:0] wrLoV;
  logic [NUM_TMR-1:0] wrHiV;

  // Configuration registers and count-pin samplers (R2, R5)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg   <= '0;
      sampQ <= '0;
    end else begin
      for (int t = 0; t < NUM_TMR; t++) begin
        if (regWe && (regAddr == ADDR_W'(ADDR_CFG0 + t)))
          cfg[t] <= tmrCfg_t'(regWdata[CFG_W-1:0]);
      end
      if (mcStrobe) sampQ <= extCnt;
    end
  end

  for (genvar gi = 0; gi < NUM_TMR; gi++) begin : gTmr
    logic fallEdge;
    logic srcEvt;
    logic enable;
    logic frozen;

    assign fallEdge = sampQ[gi] & ~extCnt[gi];
    assign srcEvt   = cfg[gi].extSrc ? fallEdge : 1'b1;
    assign enable   = cfg[gi].run & (~cfg[gi].gate | extGate[gi]);
    assign frozen   = (gi == 1) && (cfg[gi].mode == MODE_SPLIT);
    assign tickV[gi] = mcStrobe & srcEvt & enable & ~frozen;
    assign wrLoV[gi] = regWe && (regAddr == ADDR_W'(2 * gi));
    assign wrHiV[gi] = regWe && (regAddr == ADDR_W'(2 * gi + 1));
  end

  always_comb begin
    strb.tick      = tickV;
    strb.splitTick = mcStrobe & cfg[1].run & (cfg[0].mode == MODE_SPLIT);
    strb.wrLo      = wrLoV;
    strb.wrHi      = wrHiV;
  end
endmodule

// File: rtl/tcnt_dpath.sv
`timescale 1ns/100ps
module tcnt_dpath
  import tcnt_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PRE_W  = 5
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  tmrCfg_t [NUM_TMR-1:0]            cfg,
  input  tmrStrobe_t                       strb,
  input  logic [BYTE_W-1:0]                wrData,
  input  logic [NUM_TMR-1:0]               ackTimer,
  output logic [NUM_TMR-1:0][BYTE_W-1:0]   loQ,
  output logic [NUM_TMR-1:0][BYTE_W-1:0]   hiQ,
  output logic [NUM_TMR-1:0]               flagQ,
  output logic [NUM_TMR-1:0]               flagSet
);
  localparam logic [BYTE_W-1:0]   PRE_MASK = BYTE_W'((1 << PRE_W) - 1);
  localparam logic [BYTE_W-1:0]   ONE_B    = BYTE_W'(1);
  localparam logic [2*BYTE_W-1:0] ONE_W    = (2*BYTE_W)'(1);

  logic [NUM_TMR-1:0] ovfMain;
  logic               splitOvf;

  for (genvar gi = 0; gi < NUM_TMR; gi++) begin : gCnt
    logic [BYTE_W-1:0] loR, hiR, nLo, nHi;
    logic              ovf;

    always_comb begin
      nLo = loR;
      nHi = hiR;
      ovf = 1'b0;
      if (strb.tick[gi]) begin
        unique case (cfg[gi].mode)
          MODE_PRE13: begin
            nLo = (loR & ~PRE_MASK) | ((loR + ONE_B) & PRE_MASK);
            if ((loR & PRE_MASK) == PRE_MASK) begin
              nHi = hiR + ONE_B;
              ovf = &hiR;
            end
          end
          MODE_FULL16: begin
            {nHi, nLo} = {hiR, loR} + ONE_W;
            ovf = &{hiR, loR};
          end
          MODE_RELOAD8: begin
            if (&loR) begin
              nLo = hiR;
              ovf = 1'b1;
            end else begin
              nLo = loR + ONE_B;
            end
          end
          MODE_SPLIT: begin
            if (gi == 0) begin
              nLo = loR + ONE_B;
              ovf = &loR;
            end
          end
        endcase
      end
      if ((gi == 0) && strb.splitTick) nHi = hiR + ONE_B;
      if (strb.wrLo[gi]) nLo = wrData;
      if (strb.wrHi[gi]) nHi = wrData;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        loR <= '0;
        hiR <= '0;
      end else begin
        loR <= nLo;
        hiR <= nHi;
      end
    end

    assign loQ[gi]     = loR;
    assign hiQ[gi]     = hiR;
    assign ovfMain[gi] = ovf;
  end

  assign splitOvf   = strb.splitTick & (&hiQ[0]);
  assign flagSet[0] = ovfMain[0];
  assign flagSet[1] = (ovfMain[1] & (cfg[0].mode != MODE_SPLIT)) | splitOvf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= '0;
    end else begin
      for (int t = 0; t < NUM_TMR; t++) begin
        if (flagSet[t])       flagQ[t] <= 1'b1;
        else if (ackTimer[t]) flagQ[t] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tcnt_unit.sv
`timescale 1ns/100ps
module tcnt_unit
  import tcnt_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PRE_W  = 5,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mcStrobe,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BYTE_W-1:0] regWdata,
  output logic [BYTE_W-1:0] regRdata,
  input  logic [1:0]        extCnt,
  input  logic [1:0]        extGate,
  input  logic [1:0]        ackTimer,
  output logic [1:0]        ovfFlag
);
  localparam int CFG_W = $bits(tmrCfg_t);

  tmrCfg_t [NUM_TMR-1:0]            cfg;
  tmrStrobe_t                       strb;
  logic [NUM_TMR-1:0][BYTE_W-1:0]   loQ;
  logic [NUM_TMR-1:0][BYTE_W-1:0]   hiQ;
  logic [NUM_TMR-1:0]               flagQ;
  logic [NUM_TMR-1:0]               flagSet;

  tcnt_ctrl #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .mcStrobe(mcStrobe), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .extCnt(extCnt),
    .extGate(extGate), .cfg(cfg), .strb(strb)
  );

  tcnt_dpath #(.BYTE_W(BYTE_W), .PRE_W(PRE_W)) uDpath (
    .clk(clk), .rstN(rstN), .cfg(cfg), .strb(strb), .wrData(regWdata),
    .ackTimer(ackTimer), .loQ(loQ), .hiQ(hiQ), .flagQ(flagQ),
    .flagSet(flagSet)
  );

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_W'(ADDR_LO0):  regRdata = loQ[0];
      ADDR_W'(ADDR_HI0):  regRdata = hiQ[0];
      ADDR_W'(ADDR_LO1):  regRdata = loQ[1];
      ADDR_W'(ADDR_HI1):  regRdata = hiQ[1];
      ADDR_W'(ADDR_CFG0): regRdata = {{(BYTE_W-CFG_W){1'b0}}, cfg[0]};
      ADDR_W'(ADDR_CFG1): regRdata = {{(BYTE_W-CFG_W){1'b0}}, cfg[1]};
      ADDR_W'(ADDR_FLAG): regRdata = {{(BYTE_W-NUM_TMR){1'b0}}, flagQ};
      default:            regRdata = '0;
    endcase
  end

  assign ovfFlag = flagQ;
endmodule

// File: rtl/tcnt_chk.sv
`timescale 1ns/100ps
module tcnt_chk
  import tcnt_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 3
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           mcStrobe,
  input logic                           regWe,
  input logic [ADDR_W-1:0]              regAddr,
  input logic [BYTE_W-1:0]              regWdata,
  input logic [1:0]                     extGate,
  input logic [1:0]                     ackTimer,
  input tmrCfg_t [NUM_TMR-1:0]          cfg,
  input logic [NUM_TMR-1:0][BYTE_W-1:0] loQ,
  input logic [NUM_TMR-1:0][BYTE_W-1:0] hiQ,
  input logic [NUM_TMR-1:0]             flagQ,
  input logic [NUM_TMR-1:0]             flagSet
);
  a_r3_hold_without_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (!mcStrobe && !regWe) |=> ($stable(loQ) && $stable(hiQ)));

  a_r4_gate_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!regWe && cfg[0].gate && !extGate[0] && cfg[0].mode != MODE_SPLIT)
      |=> ($stable(loQ[0]) && $stable(hiQ[0])));

  a_r10_split_freeze: assert property (@(posedge clk) disable iff (!rstN)
    (cfg[1].mode == MODE_SPLIT &&
     !(regWe && (regAddr == ADDR_W'(ADDR_LO1) || regAddr == ADDR_W'(ADDR_HI1))))
      |=> ($stable(loQ[1]) && $stable(hiQ[1])));

  a_r11_ack_clears0: assert property (@(posedge clk) disable iff (!rstN)
    (ackTimer[0] && !flagSet[0]) |=> !flagQ[0]);

  a_r11_ack_clears1: assert property (@(posedge clk) disable iff (!rstN)
    (ackTimer[1] && !flagSet[1]) |=> !flagQ[1]);

  a_r11_set_wins0: assert property (@(posedge clk) disable iff (!rstN)
    flagSet[0] |=> flagQ[0]);

  a_r11_set_wins1: assert property (@(posedge clk) disable iff (!rstN)
    flagSet[1] |=> flagQ[1]);

  a_r12_write_wins: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == ADDR_W'(ADDR_LO0)) |=> (loQ[0] == $past(regWdata)));
endmodule

bind tcnt_unit tcnt_chk #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .mcStrobe(mcStrobe), .regWe(regWe),
  .regAddr(regAddr), .regWdata(regWdata), .extGate(extGate),
  .ackTimer(ackTimer), .cfg(cfg), .loQ(loQ), .hiQ(hiQ), .flagQ(flagQ),
  .flagSet(flagSet)
);

// File: tb/sim_tcnt_unit.sv
`timescale 1ns/100ps
module sim_tcnt_unit;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       mcStrobe = 1'b0;
  logic       regWe = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic [1:0] extCnt = '0;
  logic [1:0] extGate = '0;
  logic [1:0] ackTimer = '0;
  logic [1:0] ovfFlag;

  int nCmp = 0;
  int nBad = 0;
  string curReq = "R1";

  // behavioural reference state
  int mLo[2], mHi[2], mMode[2], mSrc[2], mGate[2], mRun[2], mFlag[2], mSamp[2];

  tcnt_unit u0 (
    .clk(clk), .rstN(rstN), .mcStrobe(mcStrobe), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .extCnt(extCnt), .extGate(extGate), .ackTimer(ackTimer),
    .ovfFlag(ovfFlag)
  );

  always #5 clk = ~clk;

  function automatic int modelRead(int a);
    case (a)
      0: return mLo[0];
      1: return mHi[0];
      2: return mLo[1];
      3: return mHi[1];
      4: return mRun[0]*16 + mGate[0]*8 + mSrc[0]*4 + mMode[0];
      5: return mRun[1]*16 + mGate[1]*8 + mSrc[1]*4 + mMode[1];
      6: return mFlag[1]*2 + mFlag[0];
      default: return 0;
    endcase
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 2; i++) begin
      mLo[i] = 0; mHi[i] = 0; mMode[i] = 0; mSrc[i] = 0;
      mGate[i] = 0; mRun[i] = 0; mFlag[i] = 0; mSamp[i] = 0;
    end
  endtask

  // next state from the requirements, using the inputs now applied
  task automatic modelStep();
    int  nLo[2], nHi[2];
    bit  ovf[2], tk[2];
    bit  sp, spOvf, set0, set1;
    for (int i = 0; i < 2; i++) begin
      bit en, fall;
      en   = (mRun[i] == 1) && (mGate[i] == 0 || extGate[i]);
      fall = (mSamp[i] == 1) && !extCnt[i];
      tk[i] = mcStrobe && en && (mSrc[i] == 1 ? fall : 1'b1) && !(i == 1 && mMode[1] == 3);
      nLo[i] = mLo[i]; nHi[i] = mHi[i]; ovf[i] = 0;
    end
    sp = mcStrobe && mRun[1] == 1 && mMode[0] == 3;
    for (int i = 0; i < 2; i++) begin
      if (tk[i]) begin
        case (mMode[i])
          0: begin
            if (mLo[i] % 32 == 31) begin
              nLo[i] = mLo[i] - 31;
              if (mHi[i] == 255) begin nHi[i] = 0; ovf[i] = 1; end
              else nHi[i] = mHi[i] + 1;
            end else nLo[i] = mLo[i] + 1;
          end
          1: begin
            int v;
            v = mHi[i] * 256 + mLo[i] + 1;
            if (v == 65536) begin v = 0; ovf[i] = 1; end
            nHi[i] = v / 256; nLo[i] = v % 256;
          end
          2: begin
            if (mLo[i] == 255) begin nLo[i] = mHi[i]; ovf[i] = 1; end
            else nLo[i] = mLo[i] + 1;
          end
          default: begin
            if (i == 0) begin nLo[0] = (mLo[0] + 1) % 256; ovf[0] = (mLo[0] == 255); end
          end
        endcase
      end
    end
    spOvf = 0;
    if (sp) begin nHi[0] = (mHi[0] + 1) % 256; spOvf = (mHi[0] == 255); end
    set0 = ovf[0];
    set1 = (ovf[1] && mMode[0] != 3) || spOvf;
    mFlag[0] = set0 ? 1 : (ackTimer[0] ? 0 : mFlag[0]);
    mFlag[1] = set1 ? 1 : (ackTimer[1] ? 0 : mFlag[1]);
    if (regWe) begin
      case (int'(regAddr))
        0: nLo[0] = regWdata;
        1: nHi[0] = regWdata;
        2: nLo[1] = regWdata;
        3: nHi[1] = regWdata;
        4, 5: begin
          int t;
          t = int'(regAddr) - 4;
          mMode[t] = regWdata[1:0]; mSrc[t] = regWdata[2];
          mGate[t] = regWdata[3];   mRun[t] = regWdata[4];
        end
        default: ;
      endcase
    end
    if (mcStrobe) begin mSamp[0] = extCnt[0]; mSamp[1] = extCnt[1]; end
    for (int i = 0; i < 2; i++) begin mLo[i] = nLo[i]; mHi[i] = nHi[i]; end
  endtask

  task automatic compareAll();
    logic [2:0] saved;
    saved = regAddr;
    for (int a = 0; a < 8; a++) begin
      int exp;
      regAddr = a[2:0];
      #0.5;
      exp = modelRead(a);
      nCmp++;
      if (regRdata !== exp[7:0]) begin
        nBad++;
        $display("FAIL %s addr %0d actual %02h expected %02h", curReq, a, regRdata, exp[7:0]);
      end
    end
    nCmp++;
    if (ovfFlag !== {mFlag[1][0], mFlag[0][0]}) begin
      nBad++;
      $display("FAIL %s ovfFlag actual %b expected %b", curReq, ovfFlag, {mFlag[1][0], mFlag[0][0]});
    end
    regAddr = saved;
  endtask

  // compare state, advance the model with current inputs, then cross one edge
  task automatic cyc();
    compareAll();
    modelStep();
    @(negedge clk);
  endtask

  task automatic runN(int n, int period);
    for (int k = 0; k < n; k++) begin
      mcStrobe = (k % period == period - 1);
      cyc();
    end
    mcStrobe = 1'b0;
  endtask

  task automatic wr(int a, int d);
    regWe = 1'b1; regAddr = a[2:0]; regWdata = d[7:0];
    cyc();
    regWe = 1'b0;
  endtask

  task automatic ack(int which);
    ackTimer = which[1:0];
    cyc();
    ackTimer = '0;
  endtask

  function automatic int cfgB(int run, int gate, int src, int mode);
    return run*16 + gate*8 + src*4 + mode;
  endfunction

  initial begin
    #2_000_000;
    nBad++;
    $display("FAIL watchdog actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    curReq = "R1"; cyc();

    curReq = "R2";
    wr(0, 'h12); wr(1, 'h34); wr(2, 'h56); wr(3, 'h78);
    wr(4, cfgB(0, 1, 1, 2)); wr(5, cfgB(0, 0, 1, 1)); cyc();

    curReq = "R7";
    wr(4, cfgB(1, 0, 0, 1)); wr(0, 'hF8); wr(1, 'hFF);
    runN(20, 2);
    curReq = "R3"; runN(12, 3); runN(8, 1000);
    curReq = "R11"; ack(1); cyc();

    curReq = "R6";
    wr(4, cfgB(1, 0, 0, 0)); wr(0, 'hFC); wr(1, 'hFF);
    runN(40, 1); ack(1);

    curReq = "R8";
    wr(5, cfgB(1, 0, 0, 2)); wr(2, 'hFD); wr(3, 'h80);
    runN(135, 1); ack(2);

    curReq = "R4";
    wr(5, 0);
    wr(4, cfgB(1, 1, 0, 1)); wr(0, 0); wr(1, 0);
    extGate = 2'b00; runN(6, 1);
    extGate = 2'b01; runN(6, 1);
    extGate = 2'b00; runN(4, 1);
    wr(4, cfgB(0, 0, 0, 1)); extGate = 2'b01; runN(6, 1);
    extGate = 2'b00;

    curReq = "R5";
    wr(5, cfgB(1, 0, 1, 1)); wr(2, 0); wr(3, 0);
    for (int r = 0; r < 4; r++) begin
      extCnt[1] = 1'b1; runN(3, 1);
      extCnt[1] = 1'b0; runN(3, 1);
    end
    for (int r = 0; r < 5; r++) begin
      extCnt[1] = 1'b1; runN(1, 1);
      extCnt[1] = 1'b0; runN(1, 1);
    end
    for (int k = 0; k < 12; k++) begin
      mcStrobe = (k % 3 == 2);
      extCnt[1] = (k % 3 != 0);
      cyc();
    end
    mcStrobe = 1'b0; extCnt = '0; runN(2, 1);

    curReq = "R10";
    wr(5, cfgB(1, 0, 0, 3)); wr(2, 'h55); wr(3, 'h66);
    curReq = "R9";
    wr(4, cfgB(1, 0, 0, 3)); wr(0, 'hFC); wr(1, 'hFD);
    runN(8, 1);
    curReq = "R10"; runN(4, 1);
    curReq = "R9";
    ack(3);
    wr(5, cfgB(0, 0, 0, 1)); runN(5, 1);
    wr(2, 'hFE); wr(3, 'hFF);
    wr(5, cfgB(1, 0, 0, 1)); runN(6, 1);
    wr(4, cfgB(1, 0, 0, 1)); wr(5, 0); ack(3);

    curReq = "R12";
    wr(0, 'h10); wr(1, 'h00);
    mcStrobe = 1'b1; wr(0, 'hAA);
    mcStrobe = 1'b1; wr(1, 'h33);
    wr(0, 'hFF); wr(1, 'hFF);
    mcStrobe = 1'b1; wr(0, 'h07);
    mcStrobe = 1'b0; cyc();

    curReq = "R11";
    wr(0, 'hFE); wr(1, 'hFF);
    mcStrobe = 1'b1; ackTimer = 2'b01; cyc();
    ackTimer = 2'b01; cyc();
    ackTimer = 2'b00; mcStrobe = 1'b0; cyc();
    wr(0, 'hFF); wr(1, 'hFF);
    mcStrobe = 1'b1; ackTimer = 2'b01; cyc();
    mcStrobe = 1'b0; ackTimer = 2'b00; cyc(); cyc();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule